// File: doc/BRIEF.md
# Windowed Peak Tracker and Slicer

This block receives one signed, digitized line sample per symbol period, marked by a symbol strobe. It keeps a running maximum of sample magnitude across an observation window whose length is chosen from four values, and at the close of each window it loads that maximum into a held peak reference. That reference is the amplitude against which the line is normalized.

Every strobed sample is turned into a ternary decision: a mark on the positive rail, a mark on the negative rail, or a space. The decision threshold is a programmable fraction of the held peak. A coarse 5-bit loss code, about 2 dB per step, is derived from the held peak against a nominal full-scale value. Adaptation can be paused, which freezes the reference.

Top module: `peak_slicer`

## Requirements
- R1: `winSel` values 0, 1, 2 and 3 give windows of 32, 64, 128 and 256 strobed symbols. Only cycles with `symValid` high count toward a window.
- R2: After reset, `heldPeak` equals FULL_SCALE (511 by default), `attenCode` is 0, and `markPos`, `markNeg` and `decValid` are low. The first window is 128 symbols long whatever `winSel` holds.
- R3: On the final strobed symbol of a window with `adaptEn` high, `heldPeak` takes the largest magnitude of that window, the final sample included. The visible change comes one clock later. The running maximum then restarts from zero. `heldPeak` changes at no other time.
- R4: If `adaptEn` is low on the final symbol of a window, `heldPeak` keeps its previous value.
- R5: `winSel` is sampled only on the final symbol of a window and sets the length of the next window. A change made partway through a window does not alter the current window.
- R6: The threshold is floor(`heldPeak` * k / 10), where k = 4, 5, 6 or 7 for `thrSel` = 0, 1, 2 or 3. A sample is a mark if its magnitude is at least the threshold and the sample is nonzero. A positive mark raises `markPos` and a negative mark raises `markNeg`. The decision is registered, appears one clock after the strobe together with `decValid`, and uses the `heldPeak` value held before any same-cycle update.
- R7: `attenCode` is the count of k in 1..31 for which `heldPeak` < T(k). Here T(0) = FULL_SCALE and T(k) = floor(T(k-1) * 4 / 5). The count saturates at 31.
- R8: The most negative sample value, -2^(W-1), has magnitude 2^(W-1) (512 by default) for both peak tracking and slicing.
- R9: With `symValid` low, the sample is ignored. The next cycle shows `decValid`, `markPos` and `markNeg` low, and neither the window position nor the running maximum changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Symbol strobe, one per symbol period |
| sample | input | W (10) | Signed two's-complement line sample |
| winSel | input | 2 | Observation window select |
| thrSel | input | 2 | Slicing fraction select |
| adaptEn | input | 1 | Enables updates of the held peak |
| markPos | output | 1 | Positive-rail mark decision |
| markNeg | output | 1 | Negative-rail mark decision |
| decValid | output | 1 | Decision valid, one clock after strobe |
| heldPeak | output | W (10) | Held peak reference |
| attenCode | output | 5 | Coarse attenuation code, about 2 dB per step |

## Verification
The final symbol of a window is both sliced and used to update the reference in the same cycle. The bench ends windows on samples that move the peak up or down, at every threshold setting, and checks that the decision was taken against the old reference while the new reference appears on the next clock. Changes to `winSel` and `adaptEn` on or near that final symbol are judged against a cycle-accurate model of where each window ends.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef struct packed {
    logic take;    // a strobed symbol is being accepted this cycle
    logic endWin;  // this symbol closes the current window
  } pws_strobe_t;

  // slicing fraction in tenths of the held peak
  function automatic logic [3:0] thrTenths(input logic [1:0] sel);
    return 4'd4 + {2'b00, sel};
  endfunction

  // number of 4/5 steps (about 1.94 dB each) the peak lies below full scale
  function automatic int lossSteps(input int held, input int fullScale);
    int t;
    int c;
    t = fullScale;
    c = 0;
    for (int k = 1; k <= 31; k++) begin
      t = (t * 4) / 5;
      if (held < t) c++;
    end
    return (c > 31) ? 31 : c;
  endfunction

endpackage

// File: rtl/pws_ctrl.sv
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int BASE_WIN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        symValid,
  input  logic [1:0]  winSel,
  output pws_strobe_t strobes
);
  localparam int CNT_W = $clog2(BASE_WIN * 8);

  logic [CNT_W-1:0] symCnt;
  logic [1:0]       curSel;
  logic [CNT_W-1:0] lastIdx;
  logic             atLast;

  always_comb begin
    lastIdx = CNT_W'((BASE_WIN << curSel) - 1);
    atLast  = (symCnt == lastIdx);
    strobes.take   = symValid;
    strobes.endWin = symValid && atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symCnt <= '0;
      curSel <= 2'd2;  // 4 * BASE_WIN after reset
    end else if (symValid) begin
      if (atLast) begin
        symCnt <= '0;
        curSel <= winSel;
      end else begin
        symCnt <= symCnt + 1'b1;
      end
    end
  end

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    symCnt <= lastIdx);
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobes.endWin |=> (symCnt == '0));
  a_r5_len_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.endWin |=> $stable(curSel));
  a_r9_idle_cnt: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> $stable(symCnt));

endmodule

// File: rtl/pws_datapath.sv
module pws_datapath
  import pws_pkg::*;
#(
  parameter int W          = 10,
  parameter int FULL_SCALE = (1 << (W - 1)) - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  pws_strobe_t         strobes,
  input  logic signed [W-1:0] sample,
  input  logic [1:0]          thrSel,
  input  logic                adaptEn,
  output logic                markPos,
  output logic                markNeg,
  output logic                decValid,
  output logic [W-1:0]        heldPeak,
  output logic [4:0]          attenCode
);
  localparam int PW = W + 4;

  logic [W-1:0]  mag;
  logic [W-1:0]  runMax;
  logic [W-1:0]  winMax;
  logic [PW-1:0] prod;
  logic [PW-1:0] thr;
  logic          isMark;

  always_comb begin
    mag    = sample[W-1] ? ($unsigned(~sample) + W'(1)) : $unsigned(sample);
    winMax = (mag > runMax) ? mag : runMax;
    prod   = PW'(heldPeak) * PW'(thrTenths(thrSel));
    thr    = prod / PW'(10);
    isMark = (mag != '0) && (PW'(mag) >= thr);
    attenCode = 5'(lossSteps(int'(heldPeak), FULL_SCALE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runMax   <= '0;
      heldPeak <= W'(FULL_SCALE);
      markPos  <= 1'b0;
      markNeg  <= 1'b0;
      decValid <= 1'b0;
    end else begin
      decValid <= strobes.take;
      markPos  <= strobes.take && isMark && !sample[W-1];
      markNeg  <= strobes.take && isMark && sample[W-1];
      if (strobes.endWin) begin
        runMax <= '0;
        if (adaptEn) heldPeak <= winMax;
      end else if (strobes.take) begin
        runMax <= winMax;
      end
    end
  end

  a_r3_held_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.endWin |=> $stable(heldPeak));
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.endWin && !adaptEn) |=> $stable(heldPeak));
  a_r6_one_rail: assert property (@(posedge clk) disable iff (!rstN)
    !(markPos && markNeg));
  a_r6_zero_space: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && mag == '0) |=> (!markPos && !markNeg));
  a_r9_idle_out: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.take |=> (!decValid && !markPos && !markNeg && $stable(runMax)));
  a_r7_atten_top: assert property (@(posedge clk) disable iff (!rstN)
    (heldPeak >= W'(FULL_SCALE)) |-> (attenCode == 5'd0));

endmodule

// File: rtl/peak_slicer.sv
module peak_slicer
  import pws_pkg::*;
#(
  parameter int W          = 10,
  parameter int BASE_WIN   = 32,
  parameter int FULL_SCALE = (1 << (W - 1)) - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                symValid,
  input  logic signed [W-1:0] sample,
  input  logic [1:0]          winSel,
  input  logic [1:0]          thrSel,
  input  logic                adaptEn,
  output logic                markPos,
  output logic                markNeg,
  output logic                decValid,
  output logic [W-1:0]        heldPeak,
  output logic [4:0]          attenCode
);
  pws_strobe_t strobes;

  pws_ctrl #(.BASE_WIN(BASE_WIN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .winSel   (winSel),
    .strobes  (strobes)
  );

  pws_datapath #(.W(W), .FULL_SCALE(FULL_SCALE)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sample    (sample),
    .thrSel    (thrSel),
    .adaptEn   (adaptEn),
    .markPos   (markPos),
    .markNeg   (markNeg),
    .decValid  (decValid),
    .heldPeak  (heldPeak),
    .attenCode (attenCode)
  );

endmodule

// File: tb/tb_peak_slicer.sv
module tb_peak_slicer;
  localparam int CLK_PERIOD = 10;
  localparam int FS = 511;

  logic              clk = 1'b0;
  logic              rstN;
  logic              symValid;
  logic signed [9:0] sample;
  logic [1:0]        winSel;
  logic [1:0]        thrSel;
  logic              adaptEn;
  logic              markPos, markNeg, decValid;
  logic [9:0]        heldPeak;
  logic [4:0]        attenCode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int mCnt, mLen, mRun, mHeld;

  always #(CLK_PERIOD / 2) clk = ~clk;

  peak_slicer dut (
    .clk(clk), .rstN(rstN), .symValid(symValid), .sample(sample),
    .winSel(winSel), .thrSel(thrSel), .adaptEn(adaptEn),
    .markPos(markPos), .markNeg(markNeg), .decValid(decValid),
    .heldPeak(heldPeak), .attenCode(attenCode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expAtten(input int h);
    int t = FS;
    int c = 0;
    for (int k = 1; k <= 31; k++) begin
      t = (t * 4) / 5;
      if (h < t) c++;
    end
    return (c > 31) ? 31 : c;
  endfunction

  // one strobed symbol; called at a negedge, returns at the next negedge
  task automatic symStep(input int s);
    int mag = (s < 0) ? -s : s;
    int thr = (mHeld * (4 + int'(thrSel))) / 10;
    int eP = (s > 0 && mag >= thr) ? 1 : 0;
    int eN = (s < 0 && mag >= thr) ? 1 : 0;
    if (mCnt == mLen - 1) begin
      int cand = (mag > mRun) ? mag : mRun;
      if (adaptEn) mHeld = cand;
      mRun = 0;
      mCnt = 0;
      mLen = 32 << winSel;
    end else begin
      if (mag > mRun) mRun = mag;
      mCnt++;
    end
    symValid = 1'b1;
    sample = 10'(s);
    @(negedge clk);
    chk("R6 decValid", int'(decValid), 1);
    chk("R6 markPos", int'(markPos), eP);
    chk("R6 markNeg", int'(markNeg), eN);
    chk("R1 R3 R4 R5 heldPeak", int'(heldPeak), mHeld);
    chk("R7 attenCode", int'(attenCode), expAtten(mHeld));
  endtask

  task automatic idleStep(input int s);
    symValid = 1'b0;
    sample = 10'(s);
    @(negedge clk);
    chk("R9 decValid", int'(decValid), 0);
    chk("R9 marks", int'(markPos) + int'(markNeg), 0);
    chk("R9 heldPeak", int'(heldPeak), mHeld);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    rstN = 1'b0; symValid = 1'b0; sample = '0;
    winSel = 2'd0; thrSel = 2'd2; adaptEn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mCnt = 0; mLen = 128; mRun = 0; mHeld = FS;
    // R2 reset state
    chk("R2 heldPeak", int'(heldPeak), FS);
    chk("R2 attenCode", int'(attenCode), 0);
    chk("R2 outputs", int'(markPos) + int'(markNeg) + int'(decValid), 0);

    // R9: large sample without strobe must not count or register
    for (int i = 0; i < 3; i++) idleStep(500);

    // window A: 128 symbols despite winSel=0 (R2), idle gaps inside (R9)
    for (int i = 0; i < 128; i++) begin
      thrSel = 2'(i);
      symStep(((i * 37) % 401) - 200);
      if (i % 17 == 5) idleStep(-480);
    end
    // window B: 32 symbols, sweep across held peak, winSel change mid-window (R5)
    for (int i = 0; i < 32; i++) begin
      thrSel = 2'(i / 8);
      if (i == 10) winSel = 2'd3;
      symStep(((i % 2) ? -1 : 1) * ((mHeld * (i % 8 + 3)) / 10));
    end
    // window C: 256 symbols, big peak but adaptation off at the end (R4, R8)
    for (int i = 0; i < 256; i++) begin
      thrSel = 2'(i);
      if (i == 255) begin adaptEn = 1'b0; winSel = 2'd1; end
      symStep((i == 40) ? -512 : ((i * 13) % 61) - 30);
    end
    adaptEn = 1'b1;
    // window D: 64 symbols, most negative value on the final symbol (R8)
    for (int i = 0; i < 64; i++) begin
      thrSel = 2'(i);
      if (i == 63) winSel = 2'd0;
      symStep((i == 63) ? -512 : ((i * 7) % 41) - 20);
    end
    chk("R8 heldPeak magnitude", int'(heldPeak), 512);
    // window E: 32 symbols of small amplitude, high attenuation (R7)
    for (int i = 0; i < 32; i++) begin
      thrSel = 2'(i);
      symStep(((i * 5) % 7) - 3);
    end
    // window F: all zero, held peak becomes 0
    for (int i = 0; i < 32; i++) symStep(0);
    chk("R7 atten at zero peak", int'(attenCode), expAtten(0));
    // window G: zero threshold, zero stays space, +-1 marks (R6)
    for (int i = 0; i < 32; i++) begin
      thrSel = 2'(i);
      symStep((i % 3) - 1);
    end
    // a few more windows of varied amplitude for attenuation sweep (R7)
    for (int w = 0; w < 8; w++) begin
      for (int i = 0; i < 32; i++) begin
        thrSel = 2'(i + w);
        symStep((i == 7) ? (1 << w) + 3 * w : -(i % 3));
      end
    end
    idleStep(0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule